// File: doc/BRIEF.md
# Bidirectional Signal Fault Injector

This cell sits in series on a single one-bit connection between two components, named side A and side B. A direction input chooses which side sources the value and which side receives it. While the fault control input is low, the cell passes the value through unchanged. While the control input is high, the cell corrupts the forwarded value in the way that a three-bit fault code selects. The rising edge of the control input sets the moment the fault starts. The falling edge sets the moment it ends.

Each side has a data output and an output-enable, and together these stand in for a tri-state driver. A separate flag marks an unknown value. The delay fault and the stuck-open retention interval are counted in clock cycles, and both lengths are parameters. A mode input marks the current request as permanent or transient. Two fault kinds exist only as permanent faults: open-line and stuck-open. If either is requested as transient, the cell refuses it and stays transparent, and it reports the refused request on an error output.

Top module: `bidir_fault_cell`

## Requirements
- R1: While `flt_ctl` is low the cell is transparent: the destination side outputs the source value with its enable high, and `undef_flag` is low.
- R2: With `dir_b2a` at 0, side A is the source: `b_oe` is high and `a_oe` is low. With `dir_b2a` at 1, the roles swap. The two enables are never high together. A side whose enable is low outputs data 0.
- R3: The fault is present only while `flt_ctl` is high. The outputs change in the same cycle that `flt_ctl` changes, with no register between the control input and the outputs.
- R4: Code 0 forces the destination to 0. Code 1 forces it to 1. Code 2 forwards the inverse of the source.
- R5: Code 3 (open line) drives neither side, so both enables are low. Code 5 (indeterminate) drives data 0 with the enable high and raises `undef_flag`. `undef_flag` is never high in any other case.
- R6: Code 4 (delay) forwards the source value as it was sampled at the DLY_CYC-th rising clock edge before now. The delay history always follows the selected source, whatever the fault code.
- R7: Code 6 (stuck-open) first holds the source value sampled at the last rising edge before the fault became active. Once RET_CYC rising edges have passed with the fault active, it outputs 0. The output stays 0 until the fault ends.
- R8: Code 7 means no fault: the cell stays transparent even while `flt_ctl` is high.
- R9: If `flt_perm` is 0 and `flt_ctl` is high, codes 3 and 6 are refused. The cell stays transparent and `req_err` is high. `req_err` is low in every other case.
- R10: Reset (`rst_n` low, synchronous) clears the delay history to 0, clears the retention counter, and clears the held stuck-open value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_b2a | input | 1 | 0: A sources B; 1: B sources A |
| flt_ctl | input | 1 | Fault control; high for the fault's lifetime |
| flt_perm | input | 1 | 1: permanent fault request; 0: transient |
| flt_code | input | 3 | Fault type code 0..7 |
| a_in | input | 1 | Value seen on side A |
| b_in | input | 1 | Value seen on side B |
| a_out | output | 1 | Value driven onto side A |
| a_oe | output | 1 | Drive enable for side A |
| b_out | output | 1 | Value driven onto side B |
| b_oe | output | 1 | Drive enable for side B |
| undef_flag | output | 1 | Destination carries an unknown value |
| req_err | output | 1 | Transient request for a permanent-only fault refused |

## Verification
The cell holds three pieces of state: the delay history, the retention counter, and the held stuck-open value. Each one reaches the ports only while its own fault code is active. A corrupt history or held value therefore stays hidden until a delay or stuck-open fault is requested. It then shows on the destination in the first cycle of that fault, or, for the history, up to DLY_CYC cycles later. A counter that is off by one moves the stuck-open drop to 0 by one cycle, and the bench catches this on the exact cycle. Stimulus therefore switches between the two directions, applies idle gaps, and includes long stuck-open windows, so each state element is observed at the ports.

// File: rtl/fi_pkg.sv
// Shared fault-type encoding for the injector cell.
// Assumes a 3-bit code; the numeric values are the interface contract.
package fi_pkg;
    typedef enum logic [2:0] {
        FT_STUCK0   = 3'd0,
        FT_STUCK1   = 3'd1,
        FT_FLIP     = 3'd2,
        FT_OPEN     = 3'd3,
        FT_DELAY    = 3'd4,
        FT_INDET    = 3'd5,
        FT_STUCKOPN = 3'd6,
        FT_NONE     = 3'd7
    } fault_e;

    // Fault kinds that only make sense as permanent faults.
    function automatic logic perm_only(input fault_e f);
        return (f == FT_OPEN) || (f == FT_STUCKOPN);
    endfunction
endpackage

// File: rtl/fi_delay_line.sv
// Shift register giving the value sampled DEPTH clock edges ago.
// Assumes DEPTH >= 1; reset clears the history to zero.
module fi_delay_line #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (DEPTH == 1) begin : g_single
            logic stage_q;
            // single-stage history
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_chain
            logic [DEPTH-1:0] chain_q;
            // shift the newest sample in at bit 0
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[DEPTH-2:0], din};
            end
            assign dout = chain_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/fi_retention.sv
// Stuck-open retention: captures the healthy value while inactive and
// counts active cycles up to RET_CYC, saturating there.
// Assumes RET_CYC >= 1.
module fi_retention #(
    parameter int RET_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic din,
    output logic held,
    output logic expired
);
    localparam int CW = $clog2(RET_CYC + 1);
    localparam logic [CW-1:0] RET_LIM = CW'(RET_CYC);

    logic [CW-1:0] cnt_q;
    logic          held_q;

    // count active cycles, refresh held value while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            held_q <= 1'b0;
        end else if (active) begin
            if (cnt_q != RET_LIM) cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q  <= '0;
            held_q <= din;
        end
    end

    assign held    = held_q;
    assign expired = (cnt_q == RET_LIM);
endmodule

// File: rtl/fi_fault_mux.sv
// Selects the forwarded value, drive enable and unknown flag for the
// destination side. Purely combinational; fault_on already excludes
// refused requests.
module fi_fault_mux
    import fi_pkg::*;
(
    input  fault_e code,
    input  logic   fault_on,
    input  logic   src,
    input  logic   dly_val,
    input  logic   held,
    input  logic   expired,
    output logic   val,
    output logic   drive,
    output logic   undef
);
    // choose the corruption according to the fault code
    always_comb begin
        val   = src;
        drive = 1'b1;
        undef = 1'b0;
        if (fault_on) begin
            unique case (code)
                FT_STUCK0:   val = 1'b0;
                FT_STUCK1:   val = 1'b1;
                FT_FLIP:     val = ~src;
                FT_OPEN: begin
                    val   = 1'b0;
                    drive = 1'b0;
                end
                FT_DELAY:    val = dly_val;
                FT_INDET: begin
                    val   = 1'b0;
                    undef = 1'b1;
                end
                FT_STUCKOPN: val = expired ? 1'b0 : held;
                FT_NONE:     val = src;
            endcase
        end
    end
endmodule

// File: rtl/bidir_fault_cell.sv
// Series fault injector on one bidirectional connection. Direction picks
// the source side; the control input bounds the fault in time; the code
// picks the corruption. Tri-state is expressed as data plus enable.
// Assumes DLY_CYC >= 1 and RET_CYC >= 1.
module bidir_fault_cell
    import fi_pkg::*;
#(
    parameter int DLY_CYC = 3,
    parameter int RET_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_b2a,
    input  logic       flt_ctl,
    input  logic       flt_perm,
    input  logic [2:0] flt_code,
    input  logic       a_in,
    input  logic       b_in,
    output logic       a_out,
    output logic       a_oe,
    output logic       b_out,
    output logic       b_oe,
    output logic       undef_flag,
    output logic       req_err
);
    fault_e code;
    logic   src, refused, fault_on, so_active;
    logic   dly_val, held, expired;
    logic   val, drive, undef;

    assign code      = fault_e'(flt_code);
    assign src       = dir_b2a ? b_in : a_in;
    assign refused   = flt_ctl && !flt_perm && perm_only(code);
    assign fault_on  = flt_ctl && !refused;
    assign so_active = fault_on && (code == FT_STUCKOPN);

    fi_delay_line #(.DEPTH(DLY_CYC)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (src),
        .dout (dly_val)
    );

    fi_retention #(.RET_CYC(RET_CYC)) u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (so_active),
        .din    (src),
        .held   (held),
        .expired(expired)
    );

    fi_fault_mux u_mux (
        .code    (code),
        .fault_on(fault_on),
        .src     (src),
        .dly_val (dly_val),
        .held    (held),
        .expired (expired),
        .val     (val),
        .drive   (drive),
        .undef   (undef)
    );

    // steer the result to the destination side only
    always_comb begin
        a_oe       = dir_b2a && drive;
        b_oe       = !dir_b2a && drive;
        a_out      = a_oe ? val : 1'b0;
        b_out      = b_oe ? val : 1'b0;
        undef_flag = undef;
        req_err    = refused;
    end
endmodule

// File: rtl/fi_cell_checker.sv
// Protocol checker for bidir_fault_cell, bound to every instance.
// Tracks stuck-open activity with its own counter.
module fi_cell_checker #(
    parameter int RET_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dir_b2a,
    input logic       flt_ctl,
    input logic       flt_perm,
    input logic [2:0] flt_code,
    input logic       a_in,
    input logic       b_in,
    input logic       a_out,
    input logic       a_oe,
    input logic       b_out,
    input logic       b_oe,
    input logic       undef_flag,
    input logic       req_err
);
    logic src, dst, dst_oe, so_req;
    int   so_cnt;

    assign src    = dir_b2a ? b_in : a_in;
    assign dst    = dir_b2a ? a_out : b_out;
    assign dst_oe = dir_b2a ? a_oe : b_oe;
    assign so_req = flt_ctl && flt_perm && (flt_code == 3'd6);

    // independent count of stuck-open active cycles
    always_ff @(posedge clk) begin
        if (!rst_n)                         so_cnt <= 0;
        else if (!so_req)                   so_cnt <= 0;
        else if (so_cnt < RET_CYC)          so_cnt <= so_cnt + 1;
    end

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_ctl |-> (dst_oe && dst == src && !undef_flag)); // R1
    AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)); // R2
    AST_FORCE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ctl && flt_code == 3'd1) |-> (dst_oe && dst)); // R4
    AST_FLIP_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ctl && flt_code == 3'd2) |-> (dst == !src)); // R4
    AST_OPEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ctl && flt_perm && flt_code == 3'd3) |-> (!a_oe && !b_oe)); // R5
    AST_UNDEF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (flt_ctl && flt_code == 3'd5 && dst_oe)); // R5
    AST_RET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (so_req && so_cnt >= RET_CYC) |-> (dst_oe && !dst)); // R7
    AST_CODE7_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_code == 3'd7) |-> (dst_oe && dst == src)); // R8
    AST_TRANSIENT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ctl && !flt_perm && (flt_code == 3'd3 || flt_code == 3'd6))
            |-> (req_err && dst_oe && dst == src)); // R9
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (flt_ctl && !flt_perm)); // R9
endmodule

bind bidir_fault_cell fi_cell_checker #(.RET_CYC(RET_CYC)) u_fi_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_b2a   (dir_b2a),
    .flt_ctl   (flt_ctl),
    .flt_perm  (flt_perm),
    .flt_code  (flt_code),
    .a_in      (a_in),
    .b_in      (b_in),
    .a_out     (a_out),
    .a_oe      (a_oe),
    .b_out     (b_out),
    .b_oe      (b_oe),
    .undef_flag(undef_flag),
    .req_err   (req_err)
);

// File: tb/test_bidir_fault_cell.sv
module test_bidir_fault_cell;
    localparam int DLY = 3;
    localparam int RET = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_b2a = 1'b0, flt_ctl = 1'b0, flt_perm = 1'b0;
    logic [2:0] flt_code = 3'd7;
    logic a_in = 1'b0, b_in = 1'b0;
    logic a_out, a_oe, b_out, b_oe, undef_flag, req_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    bit m_hist[$];
    bit m_hold;
    int m_cnt;

    always #2.5 clk = ~clk;

    bidir_fault_cell #(.DLY_CYC(DLY), .RET_CYC(RET)) i_bidir_fault_cell (
        .clk(clk), .rst_n(rst_n), .dir_b2a(dir_b2a), .flt_ctl(flt_ctl),
        .flt_perm(flt_perm), .flt_code(flt_code), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .undef_flag(undef_flag), .req_err(req_err)
    );

    initial begin
        for (int i = 0; i < DLY; i++) m_hist.push_back(1'b0);
        m_hold = 1'b0;
        m_cnt  = 0;
    end

    // reference model state update at each rising edge
    always @(posedge clk) begin
        bit s;
        s = dir_b2a ? b_in : a_in;
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) m_hist[i] = 1'b0;
            m_hold = 1'b0;
            m_cnt  = 0;
        end else begin
            m_hist.push_front(s);
            void'(m_hist.pop_back());
            if (flt_ctl && flt_perm && flt_code == 3'd6) begin
                if (m_cnt < RET) m_cnt++;
            end else begin
                m_cnt  = 0;
                m_hold = s;
            end
        end
    end

    // compare outputs against expectation, then advance one cycle
    task automatic tick(input string tag);
        bit s, refuse, on, ev, ed, ex;
        logic [5:0] exp_v, act_v;
        #1;
        s      = dir_b2a ? b_in : a_in;
        refuse = flt_ctl && !flt_perm && (flt_code == 3'd3 || flt_code == 3'd6);
        on     = flt_ctl && !refuse;
        ev = s; ed = 1'b1; ex = 1'b0;
        if (on) begin
            case (flt_code)
                3'd0: ev = 1'b0;
                3'd1: ev = 1'b1;
                3'd2: ev = !s;
                3'd3: begin ev = 1'b0; ed = 1'b0; end
                3'd4: ev = m_hist[DLY-1];
                3'd5: begin ev = 1'b0; ex = 1'b1; end
                3'd6: ev = (m_cnt >= RET) ? 1'b0 : m_hold;
                default: ;
            endcase
        end
        exp_v = {(dir_b2a && ed) ? ev : 1'b0, dir_b2a && ed,
                 (!dir_b2a && ed) ? ev : 1'b0, !dir_b2a && ed, ex, refuse};
        act_v = {a_out, a_oe, b_out, b_oe, undef_flag, req_err};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: {a_out,a_oe,b_out,b_oe,undef,err} actual=%b expected=%b at %0t",
                     tag, act_v, exp_v, $time);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_fault(input logic c, input logic p, input logic [2:0] k);
        flt_ctl = c; flt_perm = p; flt_code = k;
    endtask

    initial begin
        @(negedge clk);
        a_in = 1'b1;
        tick("R10");
        tick("R10");
        rst_n = 1'b1;
        // R10: delay history cleared by reset shows zeros first
        set_fault(1, 1, 3'd4);
        for (int i = 0; i < DLY + 2; i++) tick("R10");
        set_fault(0, 0, 3'd7);

        // R1 and R2: transparency in both directions, varied patterns
        for (int i = 0; i < 16; i++) begin
            dir_b2a = i[3];
            a_in = i[0] ^ i[2];
            b_in = i[1];
            tick(i[3] ? "R2" : "R1");
        end

        // R4, R3: forced and inverted values, then release
        for (int d = 0; d < 2; d++) begin
            dir_b2a = d[0];
            for (int k = 0; k < 3; k++) begin
                set_fault(1, k[0], 3'(k));
                for (int i = 0; i < 4; i++) begin
                    a_in = i[0]; b_in = i[1];
                    tick("R4");
                end
                set_fault(0, k[0], 3'(k));
                tick("R3");
            end
        end

        // R5: open line and indeterminate, both directions
        for (int d = 0; d < 2; d++) begin
            dir_b2a = d[0];
            set_fault(1, 1, 3'd3);
            a_in = 1; b_in = 1;
            tick("R5");
            tick("R5");
            set_fault(1, 0, 3'd5);
            tick("R5");
            a_in = 0; b_in = 0;
            tick("R5");
            set_fault(0, 0, 3'd7);
            tick("R3");
        end

        // R6: delay with a changing source, direction switch mid-way
        set_fault(1, 0, 3'd4);
        for (int i = 0; i < 14; i++) begin
            if (i == 7) dir_b2a = ~dir_b2a;
            a_in = i[0] ^ i[1];
            b_in = i[2] | i[0];
            tick("R6");
        end
        set_fault(0, 0, 3'd7);
        tick("R3");

        // R7: stuck-open holds then drops to 0, both held values
        for (int h = 0; h < 2; h++) begin
            dir_b2a = 1'b0;
            a_in = h[0] ? 1'b0 : 1'b1;
            tick("R7");
            set_fault(1, 1, 3'd6);
            a_in = ~a_in;
            for (int i = 0; i < RET + 3; i++) begin
                a_in = i[0];
                tick("R7");
            end
            set_fault(0, 1, 3'd6);
            tick("R7");
        end
        // R7: short activation below retention never reaches 0 phase
        a_in = 1'b1;
        tick("R7");
        set_fault(1, 1, 3'd6);
        tick("R7");
        tick("R7");
        set_fault(0, 1, 3'd6);
        tick("R7");

        // R8: code 7 is transparent
        set_fault(1, 1, 3'd7);
        for (int i = 0; i < 4; i++) begin
            dir_b2a = i[1]; a_in = i[0]; b_in = ~i[0];
            tick("R8");
        end

        // R9: transient requests for permanent-only kinds are refused
        dir_b2a = 1'b1;
        set_fault(1, 0, 3'd3);
        b_in = 1'b1;
        tick("R9");
        set_fault(1, 0, 3'd6);
        for (int i = 0; i < RET + 2; i++) begin
            b_in = i[0];
            tick("R9");
        end
        set_fault(1, 0, 3'd0);
        b_in = 1'b1;
        tick("R9");
        set_fault(0, 0, 3'd7);
        tick("R9");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule